// File: doc/BRIEF.md
# Buffered Triple-Vote Writeback Unit

This unit sits between the execute stage and the register file of a core that runs three hardware threads in a fixed interleaved order. All three threads execute the same instruction, so each instruction produces three writeback copies, one per thread. Each copy holds a write enable, a destination index and data. The copies from thread 0 and thread 1 are held in buffers that belong to those threads. When thread 2 presents its copy, the unit takes a bitwise two-out-of-three vote over the three copies and issues at most one register-file write, on the cycle after thread 2's copy arrives. A single corrupted copy therefore never reaches the register file. A one-cycle mismatch pulse reports any disagreement, and it does not hold back the write.

A read-side bypass lets a thread use a result that has not yet been committed, so that it does not wait for the vote. A thread that reads a register named by its own pending buffered copy receives that copy. Once the group has committed, threads receive the voted value. All other reads pass the register-file data through unchanged.

Top module: `tmr_wb_commit`

## Requirements
- R1: A synchronous active-high reset clears the buffers, their valid flags and the held voted value. In the cycle after reset, rf_we, vote_mismatch and fwd_hit are 0, even if a thread-2 copy was presented while reset was high.
- R2: A copy presented with ex_tid = 0 or ex_tid = 1 never causes a register-file write on the following cycle.
- R3: When ex_valid is high, ex_tid = 2, and both the thread-0 and thread-1 buffers are valid, the unit votes. If the vote allows a write, rf_we is 1 for exactly the next cycle, and rf_waddr and rf_wdata carry the bitwise majority of the three destinations and data values.
- R4: If one copy differs from the other two in any bit of data, index or write enable, the committed write equals the two agreeing copies.
- R5: No write occurs when the majority write enable is 0, or when the majority destination index is 0.
- R6: vote_mismatch is 1 for the one cycle after a vote in which any copy ({we, idx, data}) differs from the voted copy, and 0 otherwise. It does not suppress the write.
- R7: A thread-0 copy starts a new group and invalidates the thread-1 buffer. A thread-2 copy ends the group. A thread-2 copy that arrives without valid thread-0 and thread-1 buffers causes neither a write nor a mismatch.
- R8: When rd_tid selects thread 0 or 1, and that thread's buffer is valid, has write enable 1, and holds an index equal to a nonzero rd_idx, fwd_hit is 1 and fwd_data is the buffered data. This happens in the same cycle, combinationally.
- R9: Otherwise, if a committed write exists whose index equals a nonzero rd_idx, fwd_hit is 1 and fwd_data is the last committed data. If neither case applies, fwd_hit is 0 and fwd_data equals rf_rdata.
- R10: A copy presented with ex_valid = 0, or with ex_tid = 3, changes no buffer and causes no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Writeback copy present this cycle |
| ex_tid | input | 2 | Thread that produced the copy (0, 1, 2; 3 unused) |
| ex_we | input | 1 | Copy's write enable |
| ex_rd | input | AW | Copy's destination index |
| ex_data | input | XLEN | Copy's data |
| rd_tid | input | 2 | Thread performing an operand read |
| rd_idx | input | AW | Source register index being read |
| rf_rdata | input | XLEN | Register-file read data for rd_idx |
| fwd_hit | output | 1 | Operand comes from the bypass |
| fwd_data | output | XLEN | Operand value after bypass |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | AW | Register-file write index (holds the last commit) |
| rf_wdata | output | XLEN | Register-file write data (holds the last commit) |
| vote_mismatch | output | 1 | One-cycle disagreement pulse |

## Verification
The bench sweeps a single injected fault across each thread and each field: a flipped data bit, a flipped index bit and an inverted write enable. It also runs fault-free groups. For every case it computes the majority and the disagreement from the three copies it built. A design that voted only two copies, or that committed the last copy presented, would write the faulty value whenever thread 2 carried the fault. A design that compared only the data would miss mismatches in the index and the write enable.

Further groups drive two disabled copies, a zero destination, groups with a missing thread, and a thread-2 copy presented during reset. In each of these cases a careless design would issue a spurious write.

The bypass is checked against a model of own-buffer and voted-value priority. In particular, a new group's thread-0 copy must override an older committed value for thread 0, but not for thread 1.

// File: rtl/tvw_pkg.sv
package tvw_pkg;
    typedef enum logic [1:0] {
        TID_T0   = 2'd0,
        TID_T1   = 2'd1,
        TID_T2   = 2'd2,
        TID_NONE = 2'd3
    } tid_e;
endpackage

// File: rtl/tvw_maj.sv
module tvw_maj #(
    parameter int W = 8
) (
    input  logic [W-1:0] cp0,
    input  logic [W-1:0] cp1,
    input  logic [W-1:0] cp2,
    output logic [W-1:0] vote,
    output logic         disagree
);
    // bitwise two-out-of-three, one gate tree per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign vote[i] = (cp0[i] & cp1[i]) | (cp0[i] & cp2[i]) | (cp1[i] & cp2[i]);
    end

    assign disagree = (cp0 != vote) | (cp1 != vote) | (cp2 != vote);
endmodule

// File: rtl/tvw_fwd.sv
module tvw_fwd #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            own_vld,
    input  logic            own_we,
    input  logic [AW-1:0]   own_idx,
    input  logic [XLEN-1:0] own_data,
    input  logic            vot_vld,
    input  logic [AW-1:0]   vot_idx,
    input  logic [XLEN-1:0] vot_data,
    input  logic [AW-1:0]   rd_idx,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            hit,
    output logic [XLEN-1:0] data
);
    logic nz, own_hit, vot_hit;

    assign nz      = (rd_idx != '0);
    assign own_hit = nz && own_vld && own_we && (own_idx == rd_idx);
    assign vot_hit = nz && vot_vld && (vot_idx == rd_idx);

    always_comb begin
        hit  = own_hit | vot_hit;
        data = rf_rdata;
        if (own_hit)      data = own_data;
        else if (vot_hit) data = vot_data;
    end
endmodule

// File: rtl/tmr_wb_commit.sv
module tmr_wb_commit
    import tvw_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ex_valid,
    input  logic [1:0]      ex_tid,
    input  logic            ex_we,
    input  logic [AW-1:0]   ex_rd,
    input  logic [XLEN-1:0] ex_data,
    input  logic [1:0]      rd_tid,
    input  logic [AW-1:0]   rd_idx,
    input  logic [XLEN-1:0] rf_rdata,
    output logic            fwd_hit,
    output logic [XLEN-1:0] fwd_data,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            vote_mismatch
);
    localparam int EW     = 1 + AW + XLEN;
    localparam int WE_BIT = EW - 1;
    localparam int NBUF   = 2;

    typedef struct packed {
        logic [NBUF-1:0][EW-1:0] bufs;
        logic [NBUF-1:0]         vld;
        logic                    vot_vld;
        logic                    wr;
        logic [AW-1:0]           waddr;
        logic [XLEN-1:0]         wdata;
        logic                    mism;
    } st_t;

    st_t s_q, s_d;

    logic [EW-1:0]   in_ent;
    logic [EW-1:0]   maj_ent;
    logic            maj_dis;
    logic            maj_we;
    logic [AW-1:0]   maj_idx;
    logic [XLEN-1:0] maj_data;
    tid_e            tid;

    assign in_ent   = {ex_we, ex_rd, ex_data};
    assign tid      = tid_e'(ex_tid);
    assign maj_we   = maj_ent[WE_BIT];
    assign maj_idx  = maj_ent[WE_BIT-1 -: AW];
    assign maj_data = maj_ent[XLEN-1:0];

    tvw_maj #(.W(EW)) u_maj (
        .cp0      (s_q.bufs[0]),
        .cp1      (s_q.bufs[1]),
        .cp2      (in_ent),
        .vote     (maj_ent),
        .disagree (maj_dis)
    );

    always_comb begin
        s_d      = s_q;
        s_d.wr   = 1'b0;
        s_d.mism = 1'b0;
        if (ex_valid) begin
            case (tid)
                TID_T0: begin
                    s_d.bufs[0] = in_ent;
                    s_d.vld     = 2'b01;
                end
                TID_T1: begin
                    s_d.bufs[1] = in_ent;
                    s_d.vld[1]  = 1'b1;
                end
                TID_T2: begin
                    s_d.vld = '0;
                    if (&s_q.vld) begin
                        s_d.mism = maj_dis;
                        if (maj_we && (maj_idx != '0)) begin
                            s_d.wr      = 1'b1;
                            s_d.waddr   = maj_idx;
                            s_d.wdata   = maj_data;
                            s_d.vot_vld = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
        if (rst) s_d = '0;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    // operand bypass: own buffer only for threads 0 and 1
    logic          own_vld;
    logic [EW-1:0] own_ent;

    assign own_vld = !rd_tid[1] && s_q.vld[rd_tid[0]];
    assign own_ent = s_q.bufs[rd_tid[0]];

    tvw_fwd #(.XLEN(XLEN), .AW(AW)) u_fwd (
        .own_vld  (own_vld),
        .own_we   (own_ent[WE_BIT]),
        .own_idx  (own_ent[WE_BIT-1 -: AW]),
        .own_data (own_ent[XLEN-1:0]),
        .vot_vld  (s_q.vot_vld),
        .vot_idx  (s_q.waddr),
        .vot_data (s_q.wdata),
        .rd_idx   (rd_idx),
        .rf_rdata (rf_rdata),
        .hit      (fwd_hit),
        .data     (fwd_data)
    );

    assign rf_we         = s_q.wr;
    assign rf_waddr      = s_q.waddr;
    assign rf_wdata      = s_q.wdata;
    assign vote_mismatch = s_q.mism;
endmodule

// File: rtl/tvw_chk.sv
module tvw_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          ex_valid,
    input logic [1:0]    ex_tid,
    input logic [AW-1:0] rd_idx,
    input logic          fwd_hit,
    input logic          rf_we,
    input logic [AW-1:0] rf_waddr,
    input logic          vote_mismatch
);
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> !rf_we && !vote_mismatch);

    p_commit_from_t2_r3: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(ex_valid && ex_tid == 2'd2));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    p_dest_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> rf_waddr != '0);

    p_mism_from_t2_r6: assert property (@(posedge clk) disable iff (rst)
        vote_mismatch |-> $past(ex_valid && ex_tid == 2'd2));

    p_mism_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        vote_mismatch |=> !vote_mismatch);

    p_no_bypass_zero_r8: assert property (@(posedge clk) disable iff (rst)
        fwd_hit |-> rd_idx != '0);
endmodule

bind tmr_wb_commit tvw_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ex_valid      (ex_valid),
    .ex_tid        (ex_tid),
    .rd_idx        (rd_idx),
    .fwd_hit       (fwd_hit),
    .rf_we         (rf_we),
    .rf_waddr      (rf_waddr),
    .vote_mismatch (vote_mismatch)
);

// File: tb/sim_tmr_wb_commit.sv
`timescale 1ns/1ps
module sim_tmr_wb_commit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ex_valid = 1'b0;
    logic [1:0]  ex_tid = 2'd0;
    logic        ex_we = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic [31:0] ex_data = '0;
    logic [1:0]  rd_tid = 2'd0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rf_rdata = 32'hC0DE_F00D;
    logic        fwd_hit, rf_we, vote_mismatch;
    logic [31:0] fwd_data, rf_wdata;
    logic [4:0]  rf_waddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the specified behaviour
    bit          m_v0, m_v1, m_vv;
    logic [37:0] m_b0, m_b1;
    logic [4:0]  m_vidx;
    logic [31:0] m_vdata;

    always #10 clk = ~clk;

    tmr_wb_commit u0 (
        .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_tid(ex_tid),
        .ex_we(ex_we), .ex_rd(ex_rd), .ex_data(ex_data),
        .rd_tid(rd_tid), .rd_idx(rd_idx), .rf_rdata(rf_rdata),
        .fwd_hit(fwd_hit), .fwd_data(fwd_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .vote_mismatch(vote_mismatch)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive one copy at a negedge, let one posedge pass, check at next negedge
    task automatic present(input int t, input bit vld, input bit we,
                           input logic [4:0] idx, input logic [31:0] dat,
                           input string wtag);
        logic [37:0] cp, maj;
        bit exp_w, exp_m;
        cp = {we, idx, dat};
        exp_w = 1'b0;
        exp_m = 1'b0;
        maj = '0;
        if (vld && t == 2 && m_v0 && m_v1) begin
            maj = (m_b0 & m_b1) | (m_b0 & cp) | (m_b1 & cp);
            exp_m = (m_b0 != maj) || (m_b1 != maj) || (cp != maj);
            exp_w = maj[37] && (maj[36:32] != 5'd0);
        end
        ex_valid = vld; ex_tid = 2'(t); ex_we = we; ex_rd = idx; ex_data = dat;
        @(negedge clk);
        ex_valid = 1'b0;
        if (vld) begin
            if (t == 0) begin m_b0 = cp; m_v0 = 1'b1; m_v1 = 1'b0; end
            else if (t == 1) begin m_b1 = cp; m_v1 = 1'b1; end
            else if (t == 2) begin
                m_v0 = 1'b0; m_v1 = 1'b0;
                if (exp_w) begin m_vv = 1'b1; m_vidx = maj[36:32]; m_vdata = maj[31:0]; end
            end
        end
        chk(rf_we == exp_w, wtag, "rf_we", 64'(rf_we), 64'(exp_w));
        if (exp_w) begin
            chk(rf_waddr == maj[36:32], wtag, "rf_waddr", 64'(rf_waddr), 64'(maj[36:32]));
            chk(rf_wdata == maj[31:0], wtag, "rf_wdata", 64'(rf_wdata), 64'(maj[31:0]));
        end
        chk(vote_mismatch == exp_m, "R6", "vote_mismatch", 64'(vote_mismatch), 64'(exp_m));
    endtask

    task automatic fwd_check(input int t, input logic [4:0] idx, input string req);
        bit own, eh;
        logic [31:0] ed;
        own = (idx != 0) && (
              (t == 0 && m_v0 && m_b0[37] && m_b0[36:32] == idx) ||
              (t == 1 && m_v1 && m_b1[37] && m_b1[36:32] == idx));
        eh = own || ((idx != 0) && m_vv && m_vidx == idx);
        ed = own ? (t == 0 ? m_b0[31:0] : m_b1[31:0]) : (eh ? m_vdata : rf_rdata);
        rd_tid = 2'(t); rd_idx = idx;
        #1;
        chk(fwd_hit == eh, req, "fwd_hit", 64'(fwd_hit), 64'(eh));
        chk(fwd_data == ed, req, "fwd_data", 64'(fwd_data), 64'(ed));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_v0 = 0; m_v1 = 0; m_vv = 0; m_b0 = '0; m_b1 = '0; m_vidx = '0; m_vdata = '0;
        // R1: thread-2 copy held on the inputs during reset
        ex_valid = 1'b1; ex_tid = 2'd2; ex_we = 1'b1; ex_rd = 5'd5; ex_data = 32'h1234;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ex_valid = 1'b0;
        chk(rf_we == 1'b0, "R1", "rf_we in reset", 64'(rf_we), 64'd0);
        chk(vote_mismatch == 1'b0, "R1", "mismatch in reset", 64'(vote_mismatch), 64'd0);
        fwd_check(0, 5'd5, "R1");
        // R1, R7: a thread-2 copy right after reset does not write
        present(2, 1'b1, 1'b1, 5'd5, 32'h1234, "R1");

        // R3, R4: a single fault swept over thread, field and value
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 3; k++) begin
                for (int v = 0; v < 4; v++) begin
                    logic [4:0]  bi;
                    logic [31:0] bd;
                    logic [37:0] c [3];
                    bi = 5'(1 + v * 7 + f);
                    bd = 32'h3C5A_0000 + 32'(v) * 32'h0111_0111 + 32'(f) * 32'h0001_0001 + (32'(k) << 20);
                    for (int t = 0; t < 3; t++) begin
                        c[t] = {1'b1, bi, bd};
                        if (t == f) begin
                            if (k == 0) c[t][31:0] = bd ^ (32'h1 << (v * 8 + 1));
                            else if (k == 1) c[t][36:32] = bi ^ 5'(1 << v);
                            else c[t][37] = 1'b0;
                        end
                    end
                    present(0, 1'b1, c[0][37], c[0][36:32], c[0][31:0], "R2");
                    fwd_check(0, c[0][36:32], "R8");
                    present(1, 1'b1, c[1][37], c[1][36:32], c[1][31:0], "R2");
                    fwd_check(1, c[1][36:32], "R8");
                    fwd_check(0, 5'd0, "R8");
                    present(2, 1'b1, c[2][37], c[2][36:32], c[2][31:0], (f == 3) ? "R3" : "R4");
                    fwd_check(2, bi, "R9");
                    fwd_check(2, bi ^ 5'd16, "R9");
                end
            end
        end

        // R5: majority write enable low, and destination zero
        present(0, 1'b1, 1'b0, 5'd9, 32'h99, "R2");
        present(1, 1'b1, 1'b1, 5'd9, 32'h99, "R2");
        present(2, 1'b1, 1'b0, 5'd9, 32'h99, "R5");
        present(0, 1'b1, 1'b1, 5'd0, 32'h77, "R2");
        present(1, 1'b1, 1'b1, 5'd0, 32'h77, "R2");
        present(2, 1'b1, 1'b1, 5'd0, 32'h77, "R5");
        fwd_check(1, 5'd0, "R9");

        // R7: missing thread 1, and a lone thread 2 after a commit
        present(0, 1'b1, 1'b1, 5'd11, 32'hAB, "R2");
        present(2, 1'b1, 1'b1, 5'd11, 32'hAB, "R7");
        present(0, 1'b1, 1'b1, 5'd12, 32'hCD, "R2");
        present(1, 1'b1, 1'b1, 5'd12, 32'hCD, "R2");
        present(2, 1'b1, 1'b1, 5'd12, 32'hCD, "R3");
        present(2, 1'b1, 1'b1, 5'd12, 32'hCD, "R7");

        // R10: invalid copies and thread id 3 leave buffers alone
        present(0, 1'b1, 1'b1, 5'd7, 32'hAAAA_0007, "R2");
        present(0, 1'b0, 1'b1, 5'd7, 32'hBBBB_0007, "R10");
        fwd_check(0, 5'd7, "R10");
        present(3, 1'b1, 1'b1, 5'd7, 32'hCCCC_0007, "R10");
        fwd_check(0, 5'd7, "R10");
        present(1, 1'b1, 1'b1, 5'd7, 32'hAAAA_0007, "R2");
        present(2, 1'b1, 1'b1, 5'd7, 32'hAAAA_0007, "R10");

        // R8, R9: new group's own copy outranks the committed value
        present(0, 1'b1, 1'b1, 5'd7, 32'hDDDD_0007, "R2");
        fwd_check(0, 5'd7, "R8");
        fwd_check(1, 5'd7, "R9");
        fwd_check(1, 5'd3, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule